// File: doc/BRIEF.md
# Sprite DMA Address Generator

This block produces the memory read addresses for the per-line graphics fetch of one missile byte and four player bytes. Software writes two byte registers through a small write port: a DMA control byte and a base-page byte. When the timing block pulses the start of a scan line, the block captures the line number. It then requests memory once for each enabled object, and holds each request until it is granted. Every byte it reads comes out on a shared graphics data output. A one-hot strobe beside it marks which object the byte belongs to.

The control byte also carries the playfield width selection and the display-instruction fetch enable. The block decodes both and drives them out for the neighbouring fetch logic. The resolution bit changes how many base bits take part in the address. It also changes whether the line number enters whole or halved, so that at double-line resolution each byte covers two consecutive lines.

Top module: `sprite_dma_addr`

## Requirements
- R1: After reset the control and base registers are zero, so pf_width is 00, dlist_en is 0, mem_req is 0 and gfx_stb is 0.
- R2: A write with cpu_sel=0 loads the control byte and a write with cpu_sel=1 loads the base byte. pf_width follows control bits 1:0 (00 none, 01 narrow 128 color clocks, 10 standard 160, 11 wide 192). dlist_en follows control bit 5. Control bits 7:6 affect no output.
- R3: Control bit 2 enables the missile fetch and bit 3 enables the player fetch. With both set, a line_start pulse produces five fetches in this order: select 3 (missile), then selects 4, 5, 6 and 7 (players 0 to 3).
- R4: With control bit 4 = 0 (double-line), mem_addr = {base[7:2], select[2:0], line[7:1]}. Base bits 1:0 and line bit 0 do not affect it.
- R5: With control bit 4 = 1 (single-line), mem_addr = {base[7:3], select[2:0], line[7:0]}. Base bits 2:0 do not affect it.
- R6: With only player fetch enabled, a line produces exactly the four player fetches and no missile strobe.
- R7: With only missile fetch enabled, a line produces exactly one fetch, with select 3.
- R8: With neither fetch enabled, line_start produces no memory request.
- R9: mem_req stays high and mem_addr stays stable until mem_gnt. In the cycle after a grant, gfx_data holds the byte that was on mem_rdata during the grant, and gfx_stb pulses for one cycle: bit 0 for the missile, bit 1+n for player n.
- R10: line_start is ignored while a line's fetches are still pending; the line number captured at the first pulse is used for all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 1 | 0 = control byte, 1 = base byte |
| cpu_wdata | input | 8 | Write data |
| line_start | input | 1 | Start-of-line pulse from timing |
| line_num | input | 8 | Current scan line number |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | 8 | Memory read data |
| gfx_data | output | 8 | Last fetched graphics byte |
| gfx_stb | output | 5 | One-hot object strobe for gfx_data |
| pf_width | output | 2 | Decoded playfield width selection |
| dlist_en | output | 1 | Decoded display-instruction fetch enable |

## Verification
If the object select counter is wrong, the bench sees it at once on the next granted address, as a wrong or reordered select field, or as too many or too few fetches in a line. A wrong line capture or wrong resolution decode shows up in the low address bits of the first request after line_start. A strobe or data register that slips shows up one cycle after the grant, as a strobe bit that does not match the address just granted. Grant latency is varied so that the request hold and the address stability are checked across stalls.

// File: rtl/sprite_dma_addr.sv
module sprite_dma_addr (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic        cpu_sel,
  input  logic [7:0]  cpu_wdata,
  input  logic        line_start,
  input  logic [7:0]  line_num,
  output logic        mem_req,
  output logic [15:0] mem_addr,
  input  logic        mem_gnt,
  input  logic [7:0]  mem_rdata,
  output logic [7:0]  gfx_data,
  output logic [4:0]  gfx_stb,
  output logic [1:0]  pf_width,
  output logic        dlist_en
);
  localparam logic [2:0] SEL_MISSILE = 3'd3;
  localparam logic [2:0] SEL_LAST    = 3'd7;

  logic [7:0] ctrl_q, base_q, line_q;
  logic [2:0] sel;
  logic       busy;

  wire missile_en = ctrl_q[2];
  wire player_en  = ctrl_q[3];
  wire single     = ctrl_q[4];

  assign pf_width = ctrl_q[1:0];
  assign dlist_en = ctrl_q[5];
  assign mem_req  = busy;
  assign mem_addr = single ? {base_q[7:3], sel, line_q}
                           : {base_q[7:2], sel, line_q[7:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      base_q   <= '0;
      line_q   <= '0;
      sel      <= SEL_MISSILE;
      busy     <= 1'b0;
      gfx_data <= '0;
      gfx_stb  <= '0;
    end else begin
      if (cpu_wr) begin
        if (cpu_sel) base_q <= cpu_wdata;
        else         ctrl_q <= cpu_wdata;
      end
      gfx_stb <= '0;
      if (!busy) begin
        if (line_start && (missile_en || player_en)) begin
          busy   <= 1'b1;
          line_q <= line_num;
          sel    <= missile_en ? SEL_MISSILE : 3'd4;
        end
      end else if (mem_gnt) begin
        gfx_data <= mem_rdata;
        gfx_stb  <= 5'b00001 << (sel - SEL_MISSILE);
        if (sel == SEL_LAST || (sel == SEL_MISSILE && !player_en))
          busy <= 1'b0;
        else
          sel <= sel + 3'd1;
      end
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !cpu_wr |=> mem_req && $stable(mem_addr)); // R9

  AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gfx_stb)); // R9

  AST_STB_AFTER_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt |=> gfx_stb != 5'b0); // R9

  AST_NO_STRAY_STB: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_stb != 5'b0 |-> $past(mem_req && mem_gnt)); // R9

  AST_MISSILE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) && ctrl_q[2] && !ctrl_q[4] && !$past(cpu_wr) |-> mem_addr[9:7] == 3'd3); // R3

  AST_IDLE_WITHOUT_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_req && !ctrl_q[2] && !ctrl_q[3] && !cpu_wr |=> !mem_req); // R8
endmodule

// File: tb/sprite_dma_addr_test.sv
module sprite_dma_addr_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cpu_wr = 0, cpu_sel = 0, line_start = 0;
  logic [7:0] cpu_wdata = 0, line_num = 0;
  logic mem_req, mem_gnt, dlist_en;
  logic [15:0] mem_addr;
  logic [7:0] mem_rdata, gfx_data;
  logic [4:0] gfx_stb;
  logic [1:0] pf_width;

  always #5 clk = ~clk;

  sprite_dma_addr uut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_sel(cpu_sel),
    .cpu_wdata(cpu_wdata), .line_start(line_start), .line_num(line_num),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .gfx_data(gfx_data), .gfx_stb(gfx_stb),
    .pf_width(pf_width), .dlist_en(dlist_en)
  );

  int gnt_wait = 0;
  int wcnt = 0;
  always_ff @(posedge clk) wcnt <= (mem_req && !mem_gnt) ? wcnt + 1 : 0;
  assign mem_gnt   = mem_req && (wcnt >= gnt_wait);
  assign mem_rdata = mem_addr[7:0] ^ mem_addr[15:8] ^ 8'h5A;

  logic clr = 0;
  logic [15:0] got_addr [0:15];
  logic [7:0]  got_data [0:15];
  logic [4:0]  got_stb  [0:15];
  int n_addr = 0, n_gfx = 0;
  logic [15:0] held_addr;
  int hold_bad = 0;
  logic prev_wait = 0;

  always @(negedge clk) begin
    if (clr) begin
      n_addr = 0; n_gfx = 0; hold_bad = 0; prev_wait = 0;
    end else begin
      if (prev_wait && (!mem_req || mem_addr != held_addr)) hold_bad = hold_bad + 1;
      prev_wait = mem_req && !mem_gnt;
      held_addr = mem_addr;
      if (mem_req && mem_gnt && n_addr < 16) begin
        got_addr[n_addr] = mem_addr; n_addr = n_addr + 1;
      end
      if (gfx_stb != 0 && n_gfx < 16) begin
        got_data[n_gfx] = gfx_data; got_stb[n_gfx] = gfx_stb; n_gfx = n_gfx + 1;
      end
    end
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_addr(logic [7:0] c, logic [7:0] b, logic [7:0] l, int s);
    logic [2:0] s3 = s[2:0];
    return c[4] ? {b[7:3], s3, l} : {b[7:2], s3, l[7:1]};
  endfunction

  task automatic wr(logic s, logic [7:0] d);
    @(posedge clk); #2;
    cpu_wr = 1; cpu_sel = s; cpu_wdata = d;
    @(posedge clk); #2;
    cpu_wr = 0;
  endtask

  task automatic run(logic [7:0] c, logic [7:0] b, logic [7:0] l, int w, int extra_pulse);
    int sels [0:4];
    int n = 0;
    string rc, ra;
    wr(0, c); wr(1, b);
    gnt_wait = w;
    @(posedge clk); #2; clr = 1;
    @(posedge clk); #2; clr = 0;
    line_num = l; line_start = 1;
    @(posedge clk); #2; line_start = 0; line_num = 8'h00;
    if (extra_pulse != 0) begin
      @(posedge clk); #2; line_num = l ^ 8'hFF; line_start = 1;
      @(posedge clk); #2; line_start = 0;
    end
    repeat (60) @(posedge clk);
    #2;
    if (c[2]) begin sels[n] = 3; n++; end
    if (c[3]) for (int p = 4; p < 8; p++) begin sels[n] = p; n++; end
    rc = (c[3:2] == 2'b11) ? (extra_pulse != 0 ? "R10" : "R3") :
         (c[3:2] == 2'b10) ? "R6" : (c[3:2] == 2'b01) ? "R7" : "R8";
    ra = c[4] ? "R5" : "R4";
    chk(rc, "fetch count", n_addr, n);
    chk("R9", "strobe count", n_gfx, n);
    chk("R9", "request hold", hold_bad, 0);
    for (int i = 0; i < n && i < n_addr; i++) begin
      logic [15:0] ea = exp_addr(c, b, l, sels[i]);
      chk(ra, $sformatf("%s address %0d", rc, i), got_addr[i], ea);
      if (i < n_gfx) begin
        chk("R9", "data", got_data[i], ea[7:0] ^ ea[15:8] ^ 8'h5A);
        chk("R9", "strobe", got_stb[i], 1 << (sels[i] - 3));
      end
    end
    if (c[3:2] == 2'b10)
      for (int i = 0; i < n_gfx; i++) chk("R6", "no missile strobe", got_stb[i][0], 0);
  endtask

  localparam int NV = 9;
  localparam logic [31:0] VEC [0:NV-1] = '{
    32'h0C_A7_35_00,
    32'h1C_A7_35_00,
    32'h0C_A4_34_02,
    32'h1C_F8_FF_01,
    32'h08_40_12_03,
    32'h18_43_81_00,
    32'h04_C0_7E_01,
    32'h14_2B_09_00,
    32'hDC_A7_35_00
  };

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1", "mem_req", mem_req, 0);
    chk("R1", "gfx_stb", gfx_stb, 0);
    chk("R1", "pf_width", pf_width, 0);
    chk("R1", "dlist_en", dlist_en, 0);
    rst_n = 1;
    @(posedge clk); #2;
    line_start = 1; line_num = 8'h20;
    @(posedge clk); #2; line_start = 0;
    @(posedge clk); #2;
    chk("R1", "no request after reset", mem_req, 0);

    for (int v = 0; v < NV; v++)
      run(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], int'(VEC[v][7:0]), 0);

    wr(0, 8'h01); #1; chk("R2", "pf narrow", pf_width, 1); chk("R2", "dlist off", dlist_en, 0);
    wr(0, 8'h22); #1; chk("R2", "pf standard", pf_width, 2); chk("R2", "dlist on", dlist_en, 1);
    wr(0, 8'hC3); #1; chk("R2", "pf wide", pf_width, 3); chk("R2", "bits 7:6 ignored", dlist_en, 0);
    wr(0, 8'h00); #1; chk("R2", "pf none", pf_width, 0);
    wr(1, 8'hFF); #1; chk("R2", "base write leaves ctrl", pf_width, 0);

    run(8'h00, 8'h55, 8'h10, 0, 0);
    run(8'h0C, 8'h6C, 8'h44, 2, 1);
    run(8'h1C, 8'h6C, 8'h44, 0, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule